// File: doc/BRIEF.md
# Address Match Trigger Comparator

This block watches a processor core's instruction stream and data accesses and decides, every cycle, whether any of the configured hardware debug triggers should stop the core. Each trigger supplies an already-legalized control word and one compare address. When a trigger is of an address-match kind, is armed, allows the current privilege level, and sees either the current instruction address or the current load/store address equal to its compare address, the block requests a breakpoint exception. The request arrives before the matching instruction retires or the access commits, and it carries the index of the trigger that fired.

Two address-match kinds are handled. The type-2 kind has enables only for the host privilege levels and is silenced whenever the hart runs virtualized. The type-6 kind adds separate enables for virtual user and virtual supervisor modes. Register storage, chaining, data-value compares and actions other than the breakpoint exception belong to the surrounding logic.

Top module: `addr_trigger_cmp`

## Requirements
- R1: A trigger can fire only when at least one privilege-enable bit (bits 3, 4, 6, plus bits 23 and 24 for type 6) is set and at least one of load (bit 0), store (bit 1) or execute (bit 2) is set.
- R2: An execute match needs `pc_valid`, control bit 2 set, and `pc` equal to the trigger's compare address.
- R3: A data match needs `mem_valid` and `mem_addr` equal to the compare address, with control bit 0 set for a load (`mem_is_store`=0) or bit 1 set for a store (`mem_is_store`=1).
- R4: With `virt`=0 the trigger fires only if control bit (3 + `priv`) is set, where `priv` is 0 for U (bit 3), 1 for S (bit 4), 3 for M (bit 6); `priv`=2 never fires.
- R5: A type-6 trigger with `virt`=1 tests bit 23 for `priv`=0 (VU) and bit 24 for `priv`=1 (VS); any other `priv` never fires.
- R6: A trigger whose type field (the top four bits of the control word) is 2 never fires while `virt`=1.
- R7: A trigger whose type field is neither 2 nor 6 never fires.
- R8: When several triggers match in one cycle, `bkpt_idx` reports the lowest index.
- R9: `bkpt_req` is high for exactly the cycle after each cycle in which a qualified match was seen, with `bkpt_cause` equal to 3 while it is high and 0 otherwise; with neither valid input high, no request follows.
- R10: During and directly after reset, `bkpt_req`, `bkpt_idx` and `bkpt_cause` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc | input | XLEN | Address of the instruction about to execute |
| pc_valid | input | 1 | `pc` is valid this cycle |
| mem_addr | input | XLEN | Address of the pending data access |
| mem_valid | input | 1 | A data access is pending this cycle |
| mem_is_store | input | 1 | 1 for store, 0 for load |
| priv | input | 2 | Current privilege level (0 U, 1 S, 3 M) |
| virt | input | 1 | Hart is running virtualized |
| trig_ctrl | input | NUM_TRIG*XLEN | Packed legalized control words, trigger 0 in the low slice |
| trig_addr | input | NUM_TRIG*XLEN | Packed compare addresses, trigger 0 in the low slice |
| bkpt_req | output | 1 | Breakpoint exception request |
| bkpt_idx | output | IDX_W | Index of the trigger that fired |
| bkpt_cause | output | 4 | Exception cause code (3 while requesting) |

## Verification
Every result of the block is registered once, so a request, its index and its cause code are due exactly one clock edge after the inputs that produced them. The bench drives inputs on the falling edge, lets one rising edge pass, and compares all three outputs a short delay after that edge against a behavioural model evaluated on the inputs just driven. Directed cycles target each privilege, type and priority corner, and constrained random cycles cover mixed execute and data traffic, always with the same one-edge spacing.

// File: rtl/trig_cmp_pkg.sv
package trig_cmp_pkg;

   // Control word bit positions decoded by the comparator
   localparam int CB_LOAD  = 0;
   localparam int CB_STORE = 1;
   localparam int CB_EXEC  = 2;
   localparam int CB_U     = 3;
   localparam int CB_S     = 4;
   localparam int CB_M     = 6;
   localparam int CB_VU    = 23;
   localparam int CB_VS    = 24;

   localparam logic [3:0] KIND_MC2 = 4'd2;
   localparam logic [3:0] KIND_MC6 = 4'd6;

   localparam logic [3:0] CAUSE_BREAKPOINT = 4'd3;

   typedef enum logic [1:0] {
      LVL_USER  = 2'd0,
      LVL_SUPER = 2'd1,
      LVL_RSVD  = 2'd2,
      LVL_MACH  = 2'd3
   } lvl_e;

endpackage

// File: rtl/trig_match_unit.sv
module trig_match_unit
   import trig_cmp_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] ctrl,
   input  logic [XLEN-1:0] cmp_addr,
   input  logic [XLEN-1:0] pc,
   input  logic            pc_valid,
   input  logic [XLEN-1:0] mem_addr,
   input  logic            mem_valid,
   input  logic            mem_is_store,
   input  logic [1:0]      priv,
   input  logic            virt,
   output logic            hit
);

   logic [3:0] kind;
   logic       is_mc2, is_mc6;
   logic       host_en_any, guest_en_any, mode_any, op_any, armed;
   logic       lvl_ok, kind_ok;
   logic       exec_hit, data_hit;
   logic       ctrl_unused;

   assign ctrl_unused = ^ctrl;

   always_comb begin
      kind         = ctrl[XLEN-1 -: 4];
      is_mc2       = (kind == KIND_MC2);
      is_mc6       = (kind == KIND_MC6);
      host_en_any  = ctrl[CB_U] | ctrl[CB_S] | ctrl[CB_M];
      guest_en_any = is_mc6 & (ctrl[CB_VU] | ctrl[CB_VS]);
      mode_any     = host_en_any | guest_en_any;
      op_any       = ctrl[CB_LOAD] | ctrl[CB_STORE] | ctrl[CB_EXEC];
      armed        = mode_any & op_any;

      lvl_ok = 1'b0;
      if (!virt) begin
         unique case (lvl_e'(priv))
            LVL_USER:  lvl_ok = ctrl[CB_U];
            LVL_SUPER: lvl_ok = ctrl[CB_S];
            LVL_MACH:  lvl_ok = ctrl[CB_M];
            default:   lvl_ok = 1'b0;
         endcase
      end else if (is_mc6) begin
         unique case (lvl_e'(priv))
            LVL_USER:  lvl_ok = ctrl[CB_VU];
            LVL_SUPER: lvl_ok = ctrl[CB_VS];
            default:   lvl_ok = 1'b0;
         endcase
      end

      kind_ok  = (is_mc2 & ~virt) | is_mc6;
      exec_hit = pc_valid & ctrl[CB_EXEC] & (pc == cmp_addr);
      data_hit = mem_valid & (mem_is_store ? ctrl[CB_STORE] : ctrl[CB_LOAD])
                 & (mem_addr == cmp_addr);
      hit      = kind_ok & armed & lvl_ok & (exec_hit | data_hit);
   end

endmodule

// File: rtl/trig_prio_pick.sv
module trig_prio_pick #(
   parameter int NUM   = 2,
   parameter int IDX_W = 1
) (
   input  logic [NUM-1:0]   hits,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      any = |hits;
      idx = '0;
      for (int i = NUM - 1; i >= 0; i--) begin
         if (hits[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/addr_trigger_cmp.sv
module addr_trigger_cmp
   import trig_cmp_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int NUM_TRIG = 2,
   localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [XLEN-1:0]          pc,
   input  logic                     pc_valid,
   input  logic [XLEN-1:0]          mem_addr,
   input  logic                     mem_valid,
   input  logic                     mem_is_store,
   input  logic [1:0]               priv,
   input  logic                     virt,
   input  logic [NUM_TRIG*XLEN-1:0] trig_ctrl,
   input  logic [NUM_TRIG*XLEN-1:0] trig_addr,
   output logic                     bkpt_req,
   output logic [IDX_W-1:0]         bkpt_idx,
   output logic [3:0]               bkpt_cause
);

   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("addr_trigger_cmp: XLEN must be at least 32");
      end
      if (NUM_TRIG < 1) begin : g_bad_num
         $error("addr_trigger_cmp: NUM_TRIG must be at least 1");
      end
   endgenerate

   logic [NUM_TRIG-1:0] hit_vec;
   logic                any_hit;
   logic [IDX_W-1:0]    win_idx;

   generate
      for (genvar g = 0; g < NUM_TRIG; g++) begin : g_unit
         trig_match_unit #(.XLEN(XLEN)) u_match (
            .ctrl         (trig_ctrl[g*XLEN +: XLEN]),
            .cmp_addr     (trig_addr[g*XLEN +: XLEN]),
            .pc           (pc),
            .pc_valid     (pc_valid),
            .mem_addr     (mem_addr),
            .mem_valid    (mem_valid),
            .mem_is_store (mem_is_store),
            .priv         (priv),
            .virt         (virt),
            .hit          (hit_vec[g])
         );
      end
   endgenerate

   trig_prio_pick #(.NUM(NUM_TRIG), .IDX_W(IDX_W)) u_pick (
      .hits (hit_vec),
      .any  (any_hit),
      .idx  (win_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bkpt_req   <= 1'b0;
         bkpt_idx   <= '0;
         bkpt_cause <= '0;
      end else begin
         bkpt_req   <= any_hit;
         bkpt_idx   <= any_hit ? win_idx : '0;
         bkpt_cause <= any_hit ? CAUSE_BREAKPOINT : 4'd0;
      end
   end

endmodule

// File: rtl/trig_cmp_chk.sv
module trig_cmp_chk
   import trig_cmp_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int NUM_TRIG = 2,
   parameter int IDX_W    = 1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     pc_valid,
   input logic                     mem_valid,
   input logic                     virt,
   input logic [NUM_TRIG*XLEN-1:0] trig_ctrl,
   input logic                     bkpt_req,
   input logic [IDX_W-1:0]         bkpt_idx,
   input logic [3:0]               bkpt_cause
);

   logic any_kind6, any_addr_kind, any_armed;

   always_comb begin
      any_kind6     = 1'b0;
      any_addr_kind = 1'b0;
      any_armed     = 1'b0;
      for (int t = 0; t < NUM_TRIG; t++) begin
         logic [XLEN-1:0] c;
         c = trig_ctrl[t*XLEN +: XLEN];
         if (c[XLEN-1 -: 4] == KIND_MC6) any_kind6 = 1'b1;
         if (c[XLEN-1 -: 4] == KIND_MC6 || c[XLEN-1 -: 4] == KIND_MC2)
            any_addr_kind = 1'b1;
         if ((c[CB_U] | c[CB_S] | c[CB_M] | c[CB_VU] | c[CB_VS]) &&
             (c[CB_LOAD] | c[CB_STORE] | c[CB_EXEC]))
            any_armed = 1'b1;
      end
   end

   assert_no_arm_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !any_armed |=> !bkpt_req);

   assert_virt_mc2_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (virt && !any_kind6) |=> !bkpt_req);

   assert_other_kinds_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !any_addr_kind |=> !bkpt_req);

   assert_idx_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bkpt_req |-> (int'(bkpt_idx) < NUM_TRIG));

   assert_cause_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bkpt_req |-> (bkpt_cause == CAUSE_BREAKPOINT));

   assert_cause_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bkpt_req |-> (bkpt_cause == 4'd0));

   assert_idle_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_valid && !mem_valid) |=> !bkpt_req);

endmodule

bind addr_trigger_cmp trig_cmp_chk #(
   .XLEN(XLEN), .NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pc_valid   (pc_valid),
   .mem_valid  (mem_valid),
   .virt       (virt),
   .trig_ctrl  (trig_ctrl),
   .bkpt_req   (bkpt_req),
   .bkpt_idx   (bkpt_idx),
   .bkpt_cause (bkpt_cause)
);

// File: tb/addr_trigger_cmp_tb.sv
`timescale 1ns/1ps
module addr_trigger_cmp_tb;

   localparam int XLEN = 32;
   localparam int NT   = 2;

   localparam logic [31:0] F_L  = 32'h1;
   localparam logic [31:0] F_ST = 32'h2;
   localparam logic [31:0] F_X  = 32'h4;
   localparam logic [31:0] F_U  = 32'h8;
   localparam logic [31:0] F_S  = 32'h10;
   localparam logic [31:0] F_M  = 32'h40;
   localparam logic [31:0] F_VU = 32'h0080_0000;
   localparam logic [31:0] F_VS = 32'h0100_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [XLEN-1:0] pc = '0, mem_addr = '0;
   logic pc_valid = 1'b0, mem_valid = 1'b0, mem_is_store = 1'b0;
   logic [1:0] priv = 2'd3;
   logic virt = 1'b0;
   logic [NT*XLEN-1:0] trig_ctrl = '0, trig_addr = '0;
   logic bkpt_req;
   logic [0:0] bkpt_idx;
   logic [3:0] bkpt_cause;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   addr_trigger_cmp #(.XLEN(XLEN), .NUM_TRIG(NT)) u_dut (
      .clk(clk), .rst_n(rst_n), .pc(pc), .pc_valid(pc_valid),
      .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_is_store(mem_is_store),
      .priv(priv), .virt(virt), .trig_ctrl(trig_ctrl), .trig_addr(trig_addr),
      .bkpt_req(bkpt_req), .bkpt_idx(bkpt_idx), .bkpt_cause(bkpt_cause)
   );

   function automatic logic [31:0] mk(input int kind, input logic [31:0] bits);
      return (32'(kind) << 28) | bits;
   endfunction

   // Behavioural model of one trigger
   function automatic bit model_fire(input logic [31:0] c, input logic [31:0] a);
      int kind, pos;
      bit en, ops;
      kind = int'(c[31:28]);
      if (kind != 2 && kind != 6) return 0;
      if (kind == 2 && virt) return 0;
      ops = c[0] || c[1] || c[2];
      en  = c[3] || c[4] || c[6] || (kind == 6 && (c[23] || c[24]));
      if (!ops || !en) return 0;
      if (virt) pos = (priv < 2) ? 23 + int'(priv) : -1;
      else      pos = (priv == 2) ? -1 : 3 + int'(priv);
      if (pos < 0 || !c[pos]) return 0;
      if (pc_valid && c[2] && pc == a) return 1;
      if (mem_valid && mem_addr == a) begin
         if (mem_is_store && c[1]) return 1;
         if (!mem_is_store && c[0]) return 1;
      end
      return 0;
   endfunction

   task automatic compare(input string tag, input bit er, input int ei);
      int ec;
      ec = er ? 3 : 0;
      if (!er) ei = 0;
      checks++;
      if (bkpt_req !== er || int'(bkpt_idx) != ei || int'(bkpt_cause) != ec) begin
         errors++;
         $display("FAIL %s: req/idx/cause actual=%0b/%0d/%0d expected=%0b/%0d/%0d",
                  tag, bkpt_req, bkpt_idx, bkpt_cause, er, ei, ec);
      end
   endtask

   // Inputs must be set before calling; result due one rising edge later
   task automatic step(input string tag);
      bit er;
      int ei;
      er = 0; ei = 0;
      for (int t = NT - 1; t >= 0; t--) begin
         if (model_fire(trig_ctrl[t*XLEN +: XLEN], trig_addr[t*XLEN +: XLEN])) begin
            er = 1; ei = t;
         end
      end
      @(posedge clk);
      #1;
      compare(tag, er, ei);
      @(negedge clk);
   endtask

   task automatic idle();
      pc_valid = 0; mem_valid = 0; mem_is_store = 0;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      compare("R10 in reset", 0, 0);
      @(negedge clk);
      rst_n = 1;
      idle();
      step("R10 after reset");

      trig_addr = {32'h0000_2000, 32'h0000_1000};
      // R2 execute match on trigger 0
      trig_ctrl = {mk(0, 0), mk(2, F_X | F_M)};
      priv = 3; pc = 32'h1000; pc_valid = 1;
      step("R2 exec match");
      pc = 32'h1004;
      step("R2 exec mismatch");
      // R9 next cycle with no valid must drop
      idle();
      step("R9 pulse drops");

      // R3 load / store on trigger 1
      trig_ctrl = {mk(2, F_L | F_U), mk(0, 0)};
      priv = 0; mem_addr = 32'h2000; mem_valid = 1; mem_is_store = 0;
      step("R3 load match");
      mem_is_store = 1;
      step("R3 store with only load bit");
      trig_ctrl = {mk(2, F_ST | F_U), mk(0, 0)};
      step("R3 store match");
      idle();

      // R1 arming
      trig_ctrl = {mk(0, 0), mk(2, F_X)};
      priv = 3; pc = 32'h1000; pc_valid = 1;
      step("R1 no privilege enable");
      trig_ctrl = {mk(0, 0), mk(2, F_U | F_S | F_M)};
      step("R1 no operation bit");

      // R4 privilege bit selection
      trig_ctrl = {mk(0, 0), mk(2, F_X | F_S)};
      priv = 3;
      step("R4 S-only at M");
      priv = 1;
      step("R4 S-only at S");
      trig_ctrl = {mk(0, 0), mk(2, F_X | F_U | F_S | F_M | 32'h20)};
      priv = 2;
      step("R4 reserved level");

      // R5 type 6 virtual enables
      virt = 1; priv = 0;
      trig_ctrl = {mk(0, 0), mk(6, F_X | F_VU)};
      step("R5 VU enable");
      trig_ctrl = {mk(0, 0), mk(6, F_X | F_U)};
      step("R5 host U bit in virt");
      priv = 1;
      trig_ctrl = {mk(0, 0), mk(6, F_X | F_VS)};
      step("R5 VS enable");

      // R6 type 2 silent in virt
      trig_ctrl = {mk(0, 0), mk(2, F_X | F_U | F_S | F_M)};
      step("R6 type2 virtualized");
      virt = 0;

      // R7 other types
      priv = 3;
      trig_ctrl = {mk(0, 0), mk(3, F_X | F_M)};
      step("R7 type3");
      trig_ctrl = {mk(0, 0), mk(15, F_X | F_M)};
      step("R7 type15");

      // R8 both match
      trig_addr = {32'h0000_1000, 32'h0000_1000};
      trig_ctrl = {mk(6, F_X | F_M), mk(2, F_X | F_M)};
      step("R8 both match");
      trig_ctrl = {mk(6, F_X | F_M), mk(2, F_L | F_M)};
      step("R8 only trigger1");
      idle();

      // Random traffic
      for (int n = 0; n < 600; n++) begin
         logic [31:0] a0, a1;
         a0 = 32'h100 + 32'($urandom_range(0, 3)) * 4;
         a1 = 32'h100 + 32'($urandom_range(0, 3)) * 4;
         trig_addr = {a1, a0};
         trig_ctrl = {mk(($urandom_range(0, 3) == 0) ? 5 : (($urandom_range(0, 1) == 1) ? 6 : 2),
                         32'($urandom) & 32'h0180_007F),
                      mk(($urandom_range(0, 3) == 0) ? 1 : (($urandom_range(0, 1) == 1) ? 6 : 2),
                         32'($urandom) & 32'h0180_007F)};
         pc = 32'h100 + 32'($urandom_range(0, 3)) * 4;
         mem_addr = 32'h100 + 32'($urandom_range(0, 3)) * 4;
         pc_valid = 1'($urandom);
         mem_valid = 1'($urandom);
         mem_is_store = 1'($urandom);
         priv = 2'($urandom);
         virt = 1'($urandom);
         step("R9 random traffic");
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule